// File: doc/BRIEF.md
# Bus handshake synchronizer

This block carries a word of any width from one clock domain into another clock domain with no fixed phase or frequency relation to the first. The source side copies the word into a holding register and raises a request level. That request passes through a chain of flip-flops into the destination clock. The destination register then takes the whole held word at once, under the synchronized request. The data bits are never synchronized one by one. The acknowledge returns through a second chain. A transfer is a full four-phase exchange: request up, acknowledge up, request down, acknowledge down. The next word may not start until that exchange has finished.

A parameter selects who acknowledges in the destination domain. In external mode the downstream logic drives `rx_ack_i`, and that input is the only back-pressure the block has: while it stays low the source stays blocked. In internal mode the block acknowledges for itself. `rx_valid_o` is then a single-cycle strobe that cannot be stalled, so the consumer must take `rx_data_o` on that cycle or lose it. The destination clock must sample the held word at least twice while it is stable. An optional checker (`CHECK_EN`) reports misuse of the handshake rules during simulation.

Top module: `bus_hsk_sync`

## Requirements
- R1: While `snd_rst` and `rx_rst` are high, `snd_done_o`, `rx_valid_o` and `rx_data_o` are all zero.
- R2: The word on `snd_data_i` at the `snd_clk` edge where `snd_req_i` is first seen high appears on `rx_data_o` when `rx_valid_o` rises, in both acknowledge modes.
- R3: `snd_done_o` rises only after the destination has taken the word. It falls only after `snd_req_i` has been dropped and the destination side has finished its half of the exchange. After it falls, a new transfer may begin.
- R4: Changing `snd_data_i` after the request has been accepted has no effect on the word delivered for that transfer.
- R5: With `ACK_MODE = ACK_EXT` (external), if `rx_ack_i` is held low, `rx_valid_o` stays high and `snd_done_o` stays low for as long as it is held low.
- R6: With `ACK_MODE = ACK_EXT`, `rx_data_o` does not change while `rx_valid_o` is high. `rx_valid_o` falls only after the source has dropped `snd_req_i`.
- R7: With `ACK_MODE = ACK_INT` (internal), `rx_valid_o` is high for exactly one `rx_clk` cycle per transfer.
- R8: With `ACK_MODE = ACK_INT`, `rx_ack_i` is ignored, and the exchange completes whether it is held high or low.
- R9: `rx_data_o` keeps the last delivered word after `rx_valid_o` falls, until the next transfer is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Source clock |
| snd_rst | input | 1 | Source synchronous reset, active high |
| snd_req_i | input | 1 | Source send request level |
| snd_data_i | input | DATA_W | Word to transfer |
| snd_done_o | output | 1 | Source-side acknowledge, registered |
| rx_clk | input | 1 | Destination clock |
| rx_rst | input | 1 | Destination synchronous reset, active high |
| rx_data_o | output | DATA_W | Captured word, registered |
| rx_valid_o | output | 1 | Captured word is valid, registered |
| rx_ack_i | input | 1 | Destination acknowledge (external mode only) |

## Verification
The assertions assume that the source obeys the exchange rules. It raises `snd_req_i` only while `snd_done_o` is low, and drops it only after `snd_done_o` has been seen high. In external mode they also assume that `rx_ack_i` rises only while `rx_valid_o` is high and falls only after `rx_valid_o` has fallen. The bench drives every request and acknowledge edge only after it has sampled the matching output on the opposite clock edge. The two clocks run at unrelated periods, so every wait is driven by an observed event and never by a fixed cycle count.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic {
    ACK_EXT = 1'b0,
    ACK_INT = 1'b1
  } ack_mode_e;

  localparam int MIN_STAGES = 2;
  localparam int MAX_STAGES = 10;
endpackage

// File: rtl/hsk_sync_chain.sv
module hsk_sync_chain #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[TOP-1:0], d_i};
  end

  assign q_o = chain_q[TOP];
endmodule

// File: rtl/hsk_src_ctrl.sv
module hsk_src_ctrl #(
  parameter int DATA_W     = 1,
  parameter int SRC_STAGES = 4,
  parameter bit CHECK_EN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_async_i,
  output logic              req_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              done_o
);
  logic              req_q;
  logic [DATA_W-1:0] hold_q;
  logic              ack_s;
  logic              take_word;

  hsk_sync_chain #(.STAGES(SRC_STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ack_async_i),
    .q_o (ack_s)
  );

  assign take_word = send_i && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q <= send_i;
      if (take_word) hold_q <= data_i;
    end
  end

  assign req_o  = req_q;
  assign hold_o = hold_q;
  assign done_o = ack_s;

  // R4: the held word does not move while a request is outstanding
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (req_o && $past(req_o)) |-> $stable(hold_o));

  if (CHECK_EN) begin : g_chk
    assert_send_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(send_i) |-> !done_o);
    assert_drop_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(send_i) |-> done_o);
    assert_done_falls_idle_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(done_o) |-> !send_i);
  end
endmodule

// File: rtl/hsk_dst_ctrl.sv
module hsk_dst_ctrl
  import hsk_pkg::*;
#(
  parameter int        DATA_W     = 1,
  parameter int        DST_STAGES = 4,
  parameter ack_mode_e ACK_MODE   = ACK_EXT,
  parameter bit        CHECK_EN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_async_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ack_o
);
  logic              req_s;
  logic              req_prev_q;
  logic              capture;
  logic              valid_d;
  logic              ack_d;
  logic              valid_q;
  logic              ack_q;
  logic [DATA_W-1:0] data_q;

  hsk_sync_chain #(.STAGES(DST_STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d_i (req_async_i),
    .q_o (req_s)
  );

  assign capture = req_s && !req_prev_q;

  if (ACK_MODE == ACK_INT) begin : g_int
    assign valid_d = capture;
    assign ack_d   = req_s;
  end else begin : g_ext
    assign valid_d = req_s;
    assign ack_d   = ack_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev_q <= 1'b0;
      valid_q    <= 1'b0;
      ack_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      req_prev_q <= req_s;
      valid_q    <= valid_d;
      ack_q      <= ack_d;
      if (capture) data_q <= hold_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ack_o   = ack_q;

  if (ACK_MODE == ACK_INT) begin : g_int_chk
    // R7: internal mode strobes valid for a single cycle
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);
  end else begin : g_ext_chk
    // R6: the word on the output is frozen while valid is shown
    assert_data_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      (valid_o && $past(valid_o)) |-> $stable(data_o));
    if (CHECK_EN) begin : g_proto
      assert_ack_on_valid_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_i) |-> valid_o);
      assert_ack_drop_late_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_i) |-> !valid_o);
    end
  end
endmodule

// File: rtl/bus_hsk_sync.sv
module bus_hsk_sync
  import hsk_pkg::*;
#(
  parameter int        DATA_W     = 1,
  parameter int        SRC_STAGES = 4,
  parameter int        DST_STAGES = 4,
  parameter ack_mode_e ACK_MODE   = ACK_EXT,
  parameter bit        CHECK_EN   = 1'b0
) (
  input  logic              snd_clk,
  input  logic              snd_rst,
  input  logic              snd_req_i,
  input  logic [DATA_W-1:0] snd_data_i,
  output logic              snd_done_o,
  input  logic              rx_clk,
  input  logic              rx_rst,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ack_i
);
  logic              req_x;
  logic              ack_x;
  logic [DATA_W-1:0] hold_x;

  hsk_src_ctrl #(
    .DATA_W     (DATA_W),
    .SRC_STAGES (SRC_STAGES),
    .CHECK_EN   (CHECK_EN)
  ) u_src (
    .clk         (snd_clk),
    .rst         (snd_rst),
    .send_i      (snd_req_i),
    .data_i      (snd_data_i),
    .ack_async_i (ack_x),
    .req_o       (req_x),
    .hold_o      (hold_x),
    .done_o      (snd_done_o)
  );

  hsk_dst_ctrl #(
    .DATA_W     (DATA_W),
    .DST_STAGES (DST_STAGES),
    .ACK_MODE   (ACK_MODE),
    .CHECK_EN   (CHECK_EN)
  ) u_dst (
    .clk         (rx_clk),
    .rst         (rx_rst),
    .req_async_i (req_x),
    .hold_i      (hold_x),
    .ack_i       (rx_ack_i),
    .data_o      (rx_data_o),
    .valid_o     (rx_valid_o),
    .ack_o       (ack_x)
  );
endmodule

// File: tb/tb_bus_hsk_sync.sv
module tb_bus_hsk_sync;
  import hsk_pkg::*;

  localparam int SCLK_PERIOD = 10;
  localparam int DCLK_PERIOD = 14;
  localparam int W           = 16;
  localparam int NVEC        = 6;
  localparam int TMO         = 2000;

  // {slow_ack, stimulus, expected}
  localparam logic [2*W:0] TBL [NVEC] = '{
    {1'b1, 16'hA5C3, 16'hA5C3},
    {1'b0, 16'h0000, 16'h0000},
    {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h8001, 16'h8001},
    {1'b0, 16'h1234, 16'h1234},
    {1'b0, 16'h7FFE, 16'h7FFE}
  };

  logic sclk = 1'b0, dclk = 1'b0, srst = 1'b1, drst = 1'b1;
  logic e_send = 1'b0, e_ack = 1'b0, e_done, e_valid;
  logic [W-1:0] e_data = '0, e_out;
  logic i_send = 1'b0, i_ack = 1'b0, i_done, i_valid;
  logic [W-1:0] i_data = '0, i_out;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(SCLK_PERIOD/2) sclk = ~sclk;
  always #(DCLK_PERIOD/2) dclk = ~dclk;

  bus_hsk_sync #(.DATA_W(W), .SRC_STAGES(3), .DST_STAGES(2),
                 .ACK_MODE(ACK_EXT), .CHECK_EN(1'b1)) dut (
    .snd_clk(sclk), .snd_rst(srst), .snd_req_i(e_send), .snd_data_i(e_data),
    .snd_done_o(e_done), .rx_clk(dclk), .rx_rst(drst), .rx_data_o(e_out),
    .rx_valid_o(e_valid), .rx_ack_i(e_ack));

  bus_hsk_sync #(.DATA_W(W), .SRC_STAGES(4), .DST_STAGES(4),
                 .ACK_MODE(ACK_INT), .CHECK_EN(1'b1)) dut_int (
    .snd_clk(sclk), .snd_rst(srst), .snd_req_i(i_send), .snd_data_i(i_data),
    .snd_done_o(i_done), .rx_clk(dclk), .rx_rst(drst), .rx_data_o(i_out),
    .rx_valid_o(i_valid), .rx_ack_i(i_ack));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ext_xfer(input logic [W-1:0] w, input logic [W-1:0] exp, input bit slow);
    int n;
    int bad;
    @(negedge sclk); e_data = w; e_send = 1'b1;
    @(negedge sclk); e_data = ~w;                 // R4: late change ignored
    n = 0;
    @(negedge dclk);
    while (!e_valid && n < TMO) begin @(negedge dclk); n++; end
    chk(e_valid, "R3 ext valid arrives", {31'd0, e_valid}, 1);
    chk(e_out == exp, "R2/R4 ext word", e_out, exp);
    if (slow) begin
      repeat (25) @(negedge dclk);
      chk(e_valid && !e_done, "R5 stall without ack", {e_valid, e_done}, 2'b10);
      chk(e_out == exp, "R6 word held in stall", e_out, exp);
    end
    e_ack = 1'b1;
    n = 0;
    @(negedge sclk);
    while (!e_done && n < TMO) begin @(negedge sclk); n++; end
    chk(e_done, "R3 ext done rises", {31'd0, e_done}, 1);
    e_send = 1'b0;
    n = 0; bad = 0;
    @(negedge dclk);
    while (e_valid && n < TMO) begin
      if (e_out != exp) bad++;
      @(negedge dclk); n++;
    end
    chk(!e_valid && bad == 0, "R6 valid falls, word frozen", bad, 0);
    e_ack = 1'b0;
    n = 0;
    @(negedge sclk);
    while (e_done && n < TMO) begin @(negedge sclk); n++; end
    chk(!e_done, "R3 ext done falls", {31'd0, e_done}, 0);
    chk(e_out == exp, "R9 ext word kept", e_out, exp);
  endtask

  task automatic int_xfer(input logic [W-1:0] w, input logic [W-1:0] exp, input bit ackv);
    int n;
    i_ack = ackv;                                 // R8: ignored either way
    @(negedge sclk); i_data = w; i_send = 1'b1;
    @(negedge sclk); i_data = ~w;
    n = 0;
    @(negedge dclk);
    while (!i_valid && n < TMO) begin @(negedge dclk); n++; end
    chk(i_out == exp && i_valid, "R2 int word", i_out, exp);
    @(negedge dclk);
    chk(!i_valid, "R7 single-cycle valid", {31'd0, i_valid}, 0);
    n = 0;
    @(negedge sclk);
    while (!i_done && n < TMO) begin @(negedge sclk); n++; end
    chk(i_done, "R8 int done despite ack input", {31'd0, i_done}, 1);
    i_send = 1'b0;
    n = 0;
    @(negedge sclk);
    while (i_done && n < TMO) begin @(negedge sclk); n++; end
    chk(!i_done && !i_valid, "R3 int done falls", {30'd0, i_done, i_valid}, 0);
    chk(i_out == exp, "R9 int word kept", i_out, exp);
  endtask

  initial begin
    #(SCLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge dclk);
    chk(!e_done && !e_valid && e_out == 0 && !i_done && !i_valid && i_out == 0,
        "R1 reset state", {e_done, e_valid, i_done, i_valid}, 0);
    srst = 1'b0; drst = 1'b0;
    repeat (3) @(negedge sclk);

    for (int k = 0; k < NVEC; k++) begin
      ext_xfer(TBL[k][2*W-1:W], TBL[k][W-1:0], TBL[k][2*W]);
      int_xfer(TBL[k][2*W-1:W], TBL[k][W-1:0], k[0]);
    end

    // back-to-back transfers: next word starts as soon as done falls (R3)
    ext_xfer(16'h0F0F, 16'h0F0F, 1'b0);
    ext_xfer(16'hF0F0, 16'hF0F0, 1'b0);
    int_xfer(16'h5555, 16'h5555, 1'b1);
    int_xfer(16'hAAAA, 16'hAAAA, 1'b0);

    // reset again after traffic (R1), then a fresh transfer
    @(negedge sclk); srst = 1'b1; drst = 1'b1;
    repeat (6) @(negedge dclk);
    chk(!e_done && !e_valid && e_out == 0 && i_out == 0, "R1 reset after traffic",
        e_out, 0);
    srst = 1'b0; drst = 1'b0;
    repeat (3) @(negedge sclk);
    ext_xfer(16'h3C3C, 16'h3C3C, 1'b1);
    int_xfer(16'hC3C3, 16'hC3C3, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule